// File: doc/BRIEF.md
# Serial Register Target with Protocol Error Checks

This block is a four-wire serial target that lets a host read and write a handful of 8-bit control registers. One of these registers holds the switch-control byte, which goes straight out to downstream logic. The serial clock, chip select and data input arrive asynchronously. Each one passes through a two-flop synchroniser into the system clock domain, so the serial clock must run well below a quarter of the system clock.

A command is a read/write flag, a register address and a data byte. Three framing modes are available. In single mode, the reset default, each chip-select low period carries exactly one command. In back-to-back mode, chip select may stay low across many commands. In chain mode, the data input is passed through to the data output so that the next target on the line can receive it.

The block watches for three protocol faults: a bad clock count, an access to an address that does not exist, and a checksum mismatch. Each fault has its own enable bit and its own sticky flag bit.

Top module: `spi_reg_target`

## Requirements
- R1: A command is 16 bits sent MSB first. The first bit is read/write (1 = read, 0 = write), then 7 address bits, then 8 data bits. A write to address 0x01 updates `sw_data` and nothing else changes it. After reset, `sw_data` is 0x00, the error-enable register is 0x03, the flag register is 0x00 and the mode register is 0x00.
- R2: The register map is as follows. 0x01 is the switch byte. 0x02 holds the error enables (bit0 clock count, bit1 address, bit2 checksum). 0x03 holds the error flags, using the same bit positions. 0x04 is the mode register (bit0 back-to-back, bit1 chain; chain wins when both bits are set). Unused bits read as 0.
- R3: The target samples SDI on rising SCLK and changes SDO on falling SCLK. During a read, the addressed register drives SDO MSB first in bits 9 to 16 of the same command, and SDO is 0 at all other times. Reading an address outside 0x01 to 0x04 returns 0x00. `sdo_oe` is high only while chip select is low.
- R4: In single mode, a frame is executed at chip-select rise only if it carried exactly one frame length of clocks. Otherwise it is discarded.
- R5: In back-to-back mode, each full frame is executed as soon as its last bit arrives, while chip select is still low. A trailing partial frame is discarded.
- R6: In chain mode, each SDI bit reappears on SDO 16 clocks later, and SDO is 0 for the first 16 clocks. At chip-select rise, the last 16 bits are executed as a command, but only if the clock count is a nonzero multiple of 16. Checksums are not used in chain mode.
- R7: A clock count that breaks the framing rule of the active mode sets flag bit0, if enable bit0 is set. With enable bit0 clear, the frame is still discarded but no flag is set.
- R8: A command to an address outside 0x01 to 0x04 is ignored, and it sets flag bit1 if enable bit1 is set.
- R9: With enable bit2 set (and not in chain mode), a frame is 24 bits long: the command followed by a CRC-8 over the 16 command bits. The CRC uses polynomial x^8+x^2+x+1 (0x07) and starts from 0. A CRC mismatch discards the command and sets flag bit2.
- R10: Flag bits are sticky. A flag bit clears only when the host writes 1 to that bit of register 0x03, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host or to the next target |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| sw_data | output | 8 | Switch-control byte for downstream logic |

## Verification
Any bad internal state becomes visible at the ports within one frame. A bit counter that is off by one moves read data by one SDO position, or raises a false count flag that the next flag read reports. A command decoded from the wrong window of the shift register shows up on `sw_data` a few system clocks after the commit point. In chain mode, it shows up as a wrong 16-bit delay on SDO. Stuck or self-clearing flags are exposed by reading the flag register back before and after writing 1 to each bit.

// File: rtl/spi_reg_target.sv
module spi_reg_target #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [DW-1:0] sw_data
);
  localparam int CW    = 8;
  localparam int CMD_W = 1 + AW + DW;
  localparam int FRM_W = CMD_W + CW;
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam logic [AW-1:0] A_SW = AW'(1), A_CFG = AW'(2), A_FLG = AW'(3), A_MODE = AW'(4);

  function automatic logic [CW-1:0] crc_f(input logic [CMD_W-1:0] d);
    logic [CW-1:0] c = '0;
    for (int i = CMD_W - 1; i >= 0; i--)
      c = {c[CW-2:0], 1'b0} ^ ((c[CW-1] ^ d[i]) ? POLY : '0);
    return c;
  endfunction

  logic [2:0] sck_q, cs_q;
  logic [1:0] sdi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire cs_low   = ~cs_q[1];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sck_rise = cs_low & sck_q[1] & ~sck_q[2];
  wire sck_fall = cs_low & ~sck_q[1] & sck_q[2];

  logic [DW-1:0] sw;
  logic [2:0] cfg, flg;
  logic [1:0] mode;
  wire daisy  = mode[1];
  wire burst  = mode[0] & ~mode[1];
  wire crc_on = cfg[2] & ~daisy;
  wire [CNT_W-1:0] flen = crc_on ? CNT_W'(FRM_W) : CNT_W'(CMD_W);

  logic [FRM_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic [1:0] nfr;
  logic [DW-1:0] tx;
  logic so, go;
  logic [DW-1:0] rv;

  wire wrap = sck_rise && cnt == flen - CNT_W'(1);

  always_comb
    case (sr[AW-1:0])
      A_SW:    rv = sw;
      A_CFG:   rv = {{(DW-3){1'b0}}, cfg};
      A_FLG:   rv = {{(DW-3){1'b0}}, flg};
      A_MODE:  rv = {{(DW-2){1'b0}}, mode};
      default: rv = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; cnt <= '0; nfr <= '0; tx <= '0; so <= 1'b0;
    end else if (cs_fall) begin
      sr <= '0; cnt <= '0; nfr <= '0; tx <= '0; so <= 1'b0;
    end else if (sck_rise) begin
      sr  <= {sr[FRM_W-2:0], sdi_q[1]};
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (wrap && nfr != 2'd3) nfr <= nfr + 2'd1;
    end else if (sck_fall) begin
      so <= sr[CMD_W-1];
      tx <= (cnt == CNT_W'(AW + 1)) ? (sr[AW] ? rv : '0) : {tx[DW-2:0], 1'b0};
    end

  wire commit_end = cs_rise && cnt == '0 && (daisy ? nfr != 2'd0 : (!burst && nfr == 2'd1));
  wire cnt_err    = cs_rise && (cnt != '0 || (!daisy && !burst && nfr > 2'd1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) go <= 1'b0;
    else        go <= (burst && wrap) || commit_end;

  wire [CMD_W-1:0] cmd    = crc_on ? sr[FRM_W-1:CW] : sr[CMD_W-1:0];
  wire             crc_bad = crc_on && crc_f(cmd) != sr[CW-1:0];
  wire             c_rw   = cmd[CMD_W-1];
  wire [AW-1:0]    c_addr = cmd[CMD_W-2:DW];
  wire [DW-1:0]    c_dat  = cmd[DW-1:0];
  wire             addr_ok = c_addr >= A_SW && c_addr <= A_MODE;
  wire             do_wr  = go && !crc_bad && addr_ok && !c_rw;
  wire [2:0]       clr    = (do_wr && c_addr == A_FLG) ? c_dat[2:0] : 3'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw <= '0; cfg <= 3'b011; flg <= '0; mode <= '0;
    end else begin
      if (do_wr)
        case (c_addr)
          A_SW:   sw   <= c_dat;
          A_CFG:  cfg  <= c_dat[2:0];
          A_MODE: mode <= c_dat[1:0];
          default: ;
        endcase
      flg <= (flg & ~clr) |
             {go && crc_bad, go && !crc_bad && !addr_ok && cfg[1], cnt_err && cfg[0]};
    end

  assign sdo     = daisy ? so : tx[DW-1];
  assign sdo_oe  = cs_low;
  assign sw_data = sw;

  AST_SW_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw) |-> $past(do_wr && c_addr == A_SW)); // R1
  AST_SDO_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> $stable(sdo)); // R3
  AST_CNT_FLAG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[0]) |-> $past(cfg[0] && cs_rise)); // R7
  AST_ADDR_FLAG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[1]) |-> $past(cfg[1] && go)); // R8
  AST_CRC_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && crc_bad) |=> $stable(sw) && $stable(cfg) && $stable(mode)); // R9
  AST_FLAG_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(flg) & ~flg) |-> $past(do_wr && c_addr == A_FLG)); // R10
endmodule

// File: tb/spi_reg_target_test.sv
module spi_reg_target_test;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic sdo, sdo_oe;
  logic [7:0] sw_data;
  int total = 0, bad = 0;
  logic [7:0] m_sw = 8'h00;

  always #5 clk = ~clk;

  spi_reg_target uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
                      .sdo(sdo), .sdo_oe(sdo_oe), .sw_data(sw_data));

  typedef struct {
    string       tag;
    logic [63:0] exp;
    logic [63:0] mask;
    logic [7:0]  sw;
  } item_t;
  item_t q[$];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [15:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 15; i >= 0; i--)
      c = {c[6:0], 1'b0} ^ ((c[7] ^ d[i]) ? 8'h07 : 8'h00);
    return c;
  endfunction

  function automatic logic [15:0] wr(input logic [6:0] a, input logic [7:0] d);
    return {1'b0, a, d};
  endfunction
  function automatic logic [15:0] rd(input logic [6:0] a);
    return {1'b1, a, 8'h00};
  endfunction
  function automatic logic [23:0] wc(input logic [15:0] c);
    return {c, crc8(c)};
  endfunction

  task automatic frame(input string tag, input logic [63:0] bits, input int n,
                       input logic [63:0] exp, input logic [63:0] mask);
    q.push_back('{tag, exp, mask, m_sw});
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (16) @(negedge clk);
  endtask

  // monitor: gathers SDO per chip-select window and compares with the queued item
  initial begin
    logic [63:0] cap;
    logic oe_seen;
    item_t it;
    forever begin
      @(negedge cs_n);
      cap = '0;
      oe_seen = 1'b0;
      forever begin
        @(posedge sclk or posedge cs_n);
        if (cs_n) break;
        cap = {cap[62:0], sdo};
        oe_seen = oe_seen | sdo_oe;
      end
      repeat (10) @(negedge clk);
      it = q.pop_front();
      if (it.mask != '0) chk({it.tag, " sdo"}, cap & it.mask, it.exp & it.mask);
      chk({it.tag, " sw_data"}, {56'h0, sw_data}, {56'h0, it.sw});
      chk("R3 sdo_oe during frame", {63'h0, oe_seen}, 64'h1);
      chk("R3 sdo_oe after frame", {63'h0, sdo_oe}, 64'h0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset sw_data", {56'h0, sw_data}, 64'h0);
    chk("R3 reset sdo_oe", {63'h0, sdo_oe}, 64'h0);

    frame("R2 cfg default", rd(7'h02), 16, 64'h03, 64'hFF);
    frame("R2 flag default", rd(7'h03), 16, 64'h00, 64'hFF);
    frame("R2 mode default", rd(7'h04), 16, 64'h00, 64'hFF);
    m_sw = 8'hA5;
    frame("R1 write switch", wr(7'h01, 8'hA5), 16, 0, 0);
    frame("R3 read switch", rd(7'h01), 16, 64'hA5, 64'hFFFF);

    frame("R4 short frame dropped", {48'h0, wr(7'h01, 8'h11)} >> 1, 15, 0, 0);
    m_sw = 8'h5A;
    frame("R1 write after error", wr(7'h01, 8'h5A), 16, 0, 0);
    frame("R7 count flag", rd(7'h03), 16, 64'h01, 64'hFF);
    frame("R10 clear other bits", wr(7'h03, 8'h06), 16, 0, 0);
    frame("R10 flag sticky", rd(7'h03), 16, 64'h01, 64'hFF);
    frame("R10 clear", wr(7'h03, 8'h01), 16, 0, 0);
    frame("R10 flag cleared", rd(7'h03), 16, 64'h00, 64'hFF);
    frame("R4 long frame dropped", {wr(7'h01, 8'h22), 1'b1}, 17, 0, 0);
    frame("R7 count flag long", rd(7'h03), 16, 64'h01, 64'hFF);
    frame("R10 clear", wr(7'h03, 8'h01), 16, 0, 0);

    frame("R8 bad write", wr(7'h55, 8'hFF), 16, 0, 0);
    frame("R8 bad read", rd(7'h7F), 16, 64'h00, 64'hFF);
    frame("R8 address flag", rd(7'h03), 16, 64'h02, 64'hFF);
    frame("R10 clear", wr(7'h03, 8'h02), 16, 0, 0);
    frame("R2 disable addr check", wr(7'h02, 8'h00), 16, 0, 0);
    frame("R8 bad write unflagged", wr(7'h09, 8'h33), 16, 0, 0);
    frame("R7 short unflagged", {48'h0, wr(7'h01, 8'h44)} >> 1, 15, 0, 0);
    frame("R7 R8 no flags when disabled", rd(7'h03), 16, 64'h00, 64'hFF);
    frame("R2 enable checks", wr(7'h02, 8'h03), 16, 0, 0);

    frame("R5 enter burst", wr(7'h04, 8'h01), 16, 0, 0);
    m_sw = 8'h3C;
    frame("R5 write then read", {wr(7'h01, 8'h3C), rd(7'h01)}, 32, 64'h3C, 64'hFF);
    frame("R5 single in burst", rd(7'h04), 16, 64'h01, 64'hFF);
    m_sw = 8'hC3;
    frame("R5 partial tail", {wr(7'h01, 8'hC3), 5'b10101}, 21, 0, 0);
    frame("R5 tail flagged", rd(7'h03), 16, 64'h01, 64'hFF);
    frame("R10 clear", wr(7'h03, 8'h01), 16, 0, 0);
    frame("R5 leave burst", wr(7'h04, 8'h00), 16, 0, 0);

    frame("R9 enable crc", wr(7'h02, 8'h05), 16, 0, 0);
    m_sw = 8'h77;
    frame("R9 good crc write", wc(wr(7'h01, 8'h77)), 24, 0, 0);
    frame("R9 bad crc write", wc(wr(7'h01, 8'h88)) ^ 24'h1, 24, 0, 0);
    frame("R9 crc flag", wc(rd(7'h03)), 24, 64'h0400, 64'hFFFF);
    frame("R10 clear crc", wc(wr(7'h03, 8'h04)), 24, 0, 0);
    frame("R9 short frame with crc", wr(7'h01, 8'h99), 16, 0, 0);
    frame("R9 count flag with crc", wc(rd(7'h03)), 24, 64'h0100, 64'hFFFF);
    frame("R10 clear", wc(wr(7'h03, 8'h01)), 24, 0, 0);
    frame("R9 disable crc", wc(wr(7'h02, 8'h03)), 24, 0, 0);
    frame("R2 cfg readback", rd(7'h02), 16, 64'h03, 64'hFF);

    frame("R6 enter chain", wr(7'h04, 8'h02), 16, 0, 0);
    m_sw = 8'h99;
    frame("R6 pass through", {16'hBEEF, wr(7'h01, 8'h99)}, 32, 64'h0000_BEEF, 64'hFFFF_FFFF);
    frame("R6 odd count", {wr(7'h01, 8'h11), 8'h00}, 24, 64'h00_0001, 64'hFF_FFFF);
    frame("R6 leave chain", wr(7'h04, 8'h00), 16, 64'h0, 64'hFFFF);
    frame("R6 R7 chain count flag", rd(7'h03), 16, 64'h01, 64'hFF);

    wait (q.size() == 0);
    repeat (20) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule